// File: doc/BRIEF.md
# Keypad Lock Controller with Three-Key Unlock

This block sits behind a keypad matrix scanner and decides whether the scanner may push key events into its event queue. The host arms a lock by writing 1 to a single command bit. The lock does not close at once: the controller waits until no key of the matrix is held, and only then does it gate off the event queue. While locked, no pattern of keys produces an event, except for one. When exactly the three programmed combination keys are held together, the lock opens, the command bit clears, and a one-cycle wake pulse goes to the host interrupt logic.

The command bit the host reads back tells it that a lock request is pending or in force. It does not tell the host whether the lock has actually closed. Reading 0 means that no request was made, that the request was cancelled, or that the lock has been opened. Nothing locks unless a combination has been programmed and flagged valid. The key state is a level vector sampled every cycle, and the command write is a single-cycle strobe. No data stream passes through the block, so every pin is a plain control or status signal with no valid/ready handshake. The scanner treats `evt_enable` as a qualifier on its own queue writes.

Top module: `keylock_ctrl`

## Requirements
- R1: After reset, `evt_enable` is 1, `lock_cmd_status` is 0 and `wake_pulse` is 0.
- R2: With `combo_valid` low, a command write of 1 has no effect. Dropping `combo_valid` while a request is pending or locked returns the block to the unlocked state, with `lock_cmd_status` 0 and no wake pulse.
- R3: With `combo_valid` high, a command write (`cmd_wr`=1, `cmd_wdata`=1) sets `lock_cmd_status` on the next cycle. Events stay enabled while any key is held.
- R4: A pending request closes the lock, so that `evt_enable` goes to 0, one cycle after a cycle in which no key is pressed. As long as a key stays held, the lock does not close.
- R5: `lock_cmd_status` reads 1 while the request is pending and while the lock is closed.
- R6: While locked, `evt_enable` stays 0 for any key pattern other than the exact combination, including a subset, a superset, unrelated keys or all keys.
- R7: When exactly the three combination keys are pressed while locked, `evt_enable` returns to 1 and `lock_cmd_status` to 0 on the next cycle. `wake_pulse` is 1 for exactly that one cycle.
- R8: A command write of 0 while the request is pending cancels it (`lock_cmd_status` 0, no lock when keys are released). A command write of 0 while locked is ignored.
- R9: Key index is col*ROWS+row, where bit k of `keys_down` is key k. A combination with repeated coordinates, or with an index of ROWS*COLS or above, never matches.
- R10: `wake_pulse` is raised only when the lock opens. Pressing the combination while unlocked, cancelling a request and removing the combination do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keys_down | input | ROWS*COLS | Debounced pressed state, bit col*ROWS+row |
| combo_key_a | input | IDX_W | First combination key index |
| combo_key_b | input | IDX_W | Second combination key index |
| combo_key_c | input | IDX_W | Third combination key index |
| combo_valid | input | 1 | Combination programmed |
| cmd_wr | input | 1 | One-cycle write strobe for the lock command bit |
| cmd_wdata | input | 1 | Value written to the lock command bit |
| evt_enable | output | 1 | 1 allows scanner key events, 0 discards them |
| lock_cmd_status | output | 1 | Readable lock command bit |
| wake_pulse | output | 1 | One-cycle pulse on unlock |

## Verification
The bench uses the default 8-row by 10-column matrix, which gives 80 keys with a 7-bit index. This makes reachable both the corner keys 0 and 79 in one combination and an out-of-range index of 90 that still fits the index width. The directed scenarios cover a deferred lock with a key held, an immediate lock on an idle matrix, cancel and ignored-cancel writes, near-miss patterns while locked, duplicate coordinates, and loss of the programmed combination.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [1:0] {
    LK_IDLE   = 2'd0,
    LK_ARMED  = 2'd1,
    LK_LOCKED = 2'd2
  } lk_state_e;
endpackage

// File: rtl/keylock_combo_match.sv
module keylock_combo_match #(
  parameter int NKEYS = 80,
  parameter int IDX_W = 7
) (
  input  logic [NKEYS-1:0] keys_down,
  input  logic [IDX_W-1:0] key_a,
  input  logic [IDX_W-1:0] key_b,
  input  logic [IDX_W-1:0] key_c,
  output logic             hit
);
  logic [NKEYS-1:0] want;
  logic             distinct;
  logic             in_range;

  // one bit per key: set where any programmed coordinate points
  for (genvar k = 0; k < NKEYS; k++) begin : g_mask
    assign want[k] = (key_a == IDX_W'(k)) || (key_b == IDX_W'(k)) ||
                     (key_c == IDX_W'(k));
  end

  assign distinct = (key_a != key_b) && (key_a != key_c) && (key_b != key_c);
  assign in_range = (32'(key_a) < NKEYS) && (32'(key_b) < NKEYS) &&
                    (32'(key_c) < NKEYS);
  assign hit = distinct && in_range && (keys_down == want);
endmodule

// File: rtl/keylock_fsm.sv
module keylock_fsm
  import keylock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_wdata,
  input  logic combo_valid,
  input  logic all_up,
  input  logic combo_hit,
  output logic evt_enable,
  output logic lock_cmd_status,
  output logic wake_pulse
);
  lk_state_e state_q, state_d;
  logic      wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    if (!combo_valid) begin
      state_d = LK_IDLE;
    end else begin
      unique case (state_q)
        LK_IDLE:   if (cmd_wr && cmd_wdata) state_d = LK_ARMED;
        LK_ARMED: begin
          if (cmd_wr && !cmd_wdata) state_d = LK_IDLE;
          else if (all_up)          state_d = LK_LOCKED;
        end
        LK_LOCKED: if (combo_hit) begin
          state_d = LK_IDLE;
          wake_d  = 1'b1;
        end
        default:   state_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LK_IDLE;
      wake_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      wake_pulse <= wake_d;
    end
  end

  assign evt_enable      = (state_q != LK_LOCKED);
  assign lock_cmd_status = (state_q != LK_IDLE);

  // R4: lock closes only after a cycle with every key released
  a_r4_close_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_enable && $past(evt_enable)) |-> $past(all_up));
  // R2: the lock is never in force without a programmed combination
  a_r2_lock_needs_combo: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_enable |-> $past(combo_valid));
  // R3: the command bit rises only from a valid write of 1
  a_r3_status_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_cmd_status) |-> $past(cmd_wr && cmd_wdata && combo_valid));
  // R7: wake lasts one cycle
  a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  // R10: wake only on leaving the locked state after a match
  a_r10_wake_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (evt_enable && !lock_cmd_status && $past(!evt_enable) &&
                    $past(combo_hit)));
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl #(
  parameter int ROWS  = 8,
  parameter int COLS  = 10,
  localparam int NKEYS = ROWS * COLS,
  localparam int IDX_W = $clog2(NKEYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKEYS-1:0] keys_down,
  input  logic [IDX_W-1:0] combo_key_a,
  input  logic [IDX_W-1:0] combo_key_b,
  input  logic [IDX_W-1:0] combo_key_c,
  input  logic             combo_valid,
  input  logic             cmd_wr,
  input  logic             cmd_wdata,
  output logic             evt_enable,
  output logic             lock_cmd_status,
  output logic             wake_pulse
);
  logic combo_hit;
  logic all_up;

  assign all_up = ~|keys_down;

  keylock_combo_match #(.NKEYS(NKEYS), .IDX_W(IDX_W)) u_match (
    .keys_down (keys_down),
    .key_a     (combo_key_a),
    .key_b     (combo_key_b),
    .key_c     (combo_key_c),
    .hit       (combo_hit)
  );

  keylock_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_wr          (cmd_wr),
    .cmd_wdata       (cmd_wdata),
    .combo_valid     (combo_valid),
    .all_up          (all_up),
    .combo_hit       (combo_hit),
    .evt_enable      (evt_enable),
    .lock_cmd_status (lock_cmd_status),
    .wake_pulse      (wake_pulse)
  );
endmodule

// File: tb/keylock_ctrl_tb.sv
module keylock_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int COLS = 10;
  localparam int NK = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NK-1:0] keys = '0;
  logic [6:0]    ka = '0, kb = '0, kc = '0;
  logic          cv = 1'b0, wr = 1'b0, wd = 1'b0;
  logic          en, st, wk;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keylock_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .keys_down(keys),
    .combo_key_a(ka), .combo_key_b(kb), .combo_key_c(kc),
    .combo_valid(cv), .cmd_wr(wr), .cmd_wdata(wd),
    .evt_enable(en), .lock_cmd_status(st), .wake_pulse(wk)
  );

  function automatic int kidx(int row, int col);
    return col * ROWS + row;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cmd_write(logic v);
    wr = 1'b1; wd = v; tick(); wr = 1'b0; wd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", en, 1'b1, "evt_enable");
    chk("R1", st, 1'b0, "lock_cmd_status");
    chk("R1", wk, 1'b0, "wake_pulse");
  endtask

  task automatic t_no_combo();
    cv = 1'b0; keys = '0;
    cmd_write(1'b1);
    chk("R2", st, 1'b0, "status after write without combo");
    tick();
    chk("R2", en, 1'b1, "events enabled without combo");
  endtask

  task automatic t_deferred_lock();
    ka = 7'(kidx(0,0)); kb = 7'(kidx(7,9)); kc = 7'(kidx(5,4)); cv = 1'b1;
    keys = '0; keys[kidx(2,1)] = 1'b1;
    cmd_write(1'b1);
    chk("R3", st, 1'b1, "status after write");
    chk("R3", en, 1'b1, "events while armed");
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4", en, 1'b1, "held key defers lock");
    end
    keys = '0; tick();
    chk("R4", en, 1'b0, "locked after release");
    chk("R5", st, 1'b1, "status while locked");
    chk("R10", wk, 1'b0, "no wake on lock");
  endtask

  task automatic t_locked_ignore();
    keys = '0; keys[5] = 1'b1; tick();
    chk("R6", en, 1'b0, "unrelated key");
    keys = '0; keys[ka] = 1'b1; keys[kb] = 1'b1; tick();
    chk("R6", en, 1'b0, "two of three");
    keys[kc] = 1'b1; keys[kidx(3,3)] = 1'b1; tick();
    chk("R6", en, 1'b0, "combo plus extra");
    chk("R6", wk, 1'b0, "no wake on superset");
    keys = '1; tick();
    chk("R6", en, 1'b0, "all keys");
    keys = '0;
    cmd_write(1'b0);
    chk("R8", en, 1'b0, "write 0 ignored while locked");
    chk("R8", st, 1'b1, "status kept while locked");
  endtask

  task automatic t_unlock();
    keys = '0; keys[ka] = 1'b1; keys[kb] = 1'b1; keys[kc] = 1'b1; tick();
    chk("R7", en, 1'b1, "unlocked");
    chk("R7", st, 1'b0, "status cleared");
    chk("R7", wk, 1'b1, "wake raised");
    tick();
    chk("R7", wk, 1'b0, "wake single cycle");
    chk("R10", wk, 1'b0, "combo held while idle no wake");
    keys = '0; tick();
  endtask

  task automatic t_cancel();
    keys = '0; keys[3] = 1'b1;
    cmd_write(1'b1);
    chk("R5", st, 1'b1, "status while armed");
    cmd_write(1'b0);
    chk("R8", st, 1'b0, "cancelled");
    keys = '0; tick();
    chk("R8", en, 1'b1, "no lock after cancel");
    chk("R10", wk, 1'b0, "no wake on cancel");
  endtask

  task automatic t_immediate_and_drop();
    keys = '0;
    cmd_write(1'b1);
    chk("R4", en, 1'b1, "armed one cycle");
    tick();
    chk("R4", en, 1'b0, "locked on idle matrix");
    cv = 1'b0; tick();
    chk("R2", en, 1'b1, "combo removed unlocks");
    chk("R2", st, 1'b0, "combo removed clears status");
    chk("R10", wk, 1'b0, "no wake on combo removal");
    cv = 1'b1;
  endtask

  task automatic t_bad_combo();
    ka = 7'd12; kb = 7'd12; kc = 7'd20; keys = '0;
    cmd_write(1'b1); tick();
    chk("R9", en, 1'b0, "locked for dup test");
    keys[12] = 1'b1; keys[20] = 1'b1; tick();
    chk("R9", en, 1'b0, "duplicate never matches");
    kb = 7'd90; tick();
    chk("R9", en, 1'b0, "out of range never matches");
    kb = 7'd13; keys[13] = 1'b1; tick();
    chk("R9", en, 1'b1, "fixed combo matches");
    chk("R10", wk, 1'b1, "wake on exit");
    keys = '0; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    t_reset();
    t_no_combo();
    t_deferred_lock();
    t_locked_ignore();
    t_unlock();
    t_cancel();
    t_immediate_and_drop();
    t_bad_combo();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule